// File: doc/BRIEF.md
# SPI Slave Register Access Port

This block lets an external SPI master read and write a small bank of byte-wide registers. It runs entirely in the system clock domain. The serial clock, chip select and serial input are brought in through synchronizer chains, and both edges of the serial clock are detected from the synchronized copy. Two static inputs choose the clock polarity and phase, so any of the four standard SPI modes can be used. Each byte travels most significant bit first.

A transaction begins when chip select falls. The first byte is a command: bit 7 is the direction (1 = read, 0 = write) and bits 6:0 are the starting register address. In a write, every data byte that is complete commits one register write. In a read, the addressed register is shifted out. In both cases the address then steps up by one for the next byte of a burst. The master may raise chip select at any time. That clears all serial state, and a byte that is not yet complete is dropped. The output enable is high only while read data is being sent, so the data input and data output may share one wire.

Committed writes also appear on a one-cycle event stream (`wr_valid`, `wr_addr`, `wr_data`). This stream has no ready signal and so no back-pressure. The serial master cannot be stalled, and a consumer must take every event in the cycle it is shown. Two events are always at least one serial byte time apart.

Top module: `spi_regport`

## Requirements
- R1: The first byte after chip select falls is a command. Bit 7 set means read and clear means write. Bits 6:0 are the start address, and the address also appears on `wr_addr`.
- R2: In a write, each complete data byte gives exactly one single-cycle `wr_valid` with `wr_addr` set to the current address and `wr_data` set to the byte, and updates that register. The address then increments modulo 128 for the next byte of the burst.
- R3: In a read, the data bytes are the register at the start address, then at each following address (modulo 128).
- R4: Both directions are most significant bit first. The first received bit is `wr_data[7]`, and the first bit sent is bit 7 of the register.
- R5: `sdo_oe` is high only during the read data phase of a selected transaction. It stays low during the command byte, during write data, and while chip select is high.
- R6: The sample edge is rising when `cpol == cpha` and falling otherwise. Output bits change on the opposite edge. The first read bit is valid before the first sample edge of the data byte in every mode.
- R7: Raising chip select before the sample edge of a data byte's last bit drops that byte: there is no `wr_valid` and the register keeps its value. The next transaction starts again with a command byte.
- R8: While chip select is high, serial clock and data activity has no effect: no write event occurs, the output enable stays low, and register contents are unchanged.
- R9: After reset all registers read as zero, and `wr_valid` and `sdo_oe` are low.
- R10: A register is selected by the low log2(NREG) bits of the address, so addresses that differ only in higher bits reach the same register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpol | input | 1 | Serial clock idle level (static) |
| cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge (static) |
| sclk | input | 1 | Serial clock from the master |
| cs_n | input | 1 | Chip select, active low |
| sdi | input | 1 | Serial data from the master |
| sdo_d | output | 1 | Serial data to the master |
| sdo_oe | output | 1 | Drive enable for the shared data pad |
| wr_valid | output | 1 | One-cycle write commit event |
| wr_addr | output | 7 | Address of the committed write |
| wr_data | output | 8 | Data of the committed write |

## Verification
Write and read bursts run in each of the four modes. They use byte values with different high and low halves, so a reversed bit order or a wrong sample edge gives a different byte. Bursts cross the top of the address space and use addresses that alias the same register, which separates a correct increment and index from a truncated one. Transactions are aborted during the command, during a write byte and during a read. Serial clock toggling while deselected shows whether partial state survives or whether the block reacts with chip select high.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = BYTE_W - 1;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [BYTE_W-1:0] data;
  } wr_evt_t;

  // Sampling happens on the rising edge when polarity equals phase.
  function automatic logic sample_on_rise(input logic pol, input logic pha);
    return pol == pha;
  endfunction
endpackage

// File: rtl/spi_regport_sync.sv
module spi_regport_sync #(
  parameter int unsigned     STAGES  = 2,
  parameter int unsigned     W       = 3,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(STAGES); i++) chain[i] <= RST_VAL;
    end else begin
      chain[0] <= async_i;
      for (int i = 1; i < int'(STAGES); i++) chain[i] <= chain[i-1];
    end
  end

  assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/spi_regport_edge.sv
module spi_regport_edge
  import spi_regport_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_s,
  input  logic active,
  input  logic cpol,
  input  logic cpha,
  output logic sample_o,
  output logic shift_o
);
  logic prev_q;
  logic rise, fall, on_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sclk_s;
  end

  assign rise    = sclk_s & ~prev_q;
  assign fall    = ~sclk_s & prev_q;
  assign on_rise = sample_on_rise(cpol, cpha);

  assign sample_o = active & (on_rise ? rise : fall);
  assign shift_o  = active & (on_rise ? fall : rise);
endmodule

// File: rtl/spi_regport_shift.sv
module spi_regport_shift #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         sample,
  input  logic         shift,
  input  logic         sdi_s,
  input  logic         load,
  input  logic [W-1:0] load_data,
  output logic         byte_done,
  output logic [W-1:0] byte_o,
  output logic         sdo_bit
);
  localparam int unsigned CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] cnt_q;
  logic [W-1:0]  rx_q, tx_q;
  logic          skip_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rx_q   <= '0;
      tx_q   <= '0;
      skip_q <= 1'b0;
    end else if (clear) begin
      cnt_q  <= '0;
      rx_q   <= '0;
      tx_q   <= '0;
      skip_q <= 1'b0;
    end else begin
      if (sample) begin
        rx_q  <= byte_o;
        cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end
      if (load) begin
        tx_q   <= load_data;
        skip_q <= 1'b1;
      end else if (shift) begin
        // The first shift edge after a load keeps the freshly loaded MSB.
        if (skip_q) skip_q <= 1'b0;
        else        tx_q   <= {tx_q[W-2:0], 1'b0};
      end
    end
  end

  assign byte_o    = {rx_q[W-2:0], sdi_s};
  assign byte_done = sample && (cnt_q == LAST);
  assign sdo_bit   = tx_q[W-1];
endmodule

// File: rtl/spi_regport_regs.sv
module spi_regport_regs #(
  parameter int unsigned NREG = 16,
  parameter int unsigned W    = 8,
  localparam int unsigned IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [IW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] bank [NREG];

  for (genvar g = 0; g < int'(NREG); g++) begin : g_reg
    logic [W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          q <= '0;
      else if (we && waddr == IW'(g))      q <= wdata;
    end
    assign bank[g] = q;
  end

  assign rdata = bank[raddr];
endmodule

// File: rtl/spi_regport.sv
module spi_regport
  import spi_regport_pkg::*;
#(
  parameter int unsigned NREG        = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              sdi,
  output logic              sdo_d,
  output logic              sdo_oe,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data
);
  localparam int unsigned IDX_W = $clog2(NREG);

  logic [2:0]        sync_v;
  logic              cs_idle, sclk_s, sdi_s;
  logic              sample_evt, shift_evt, tx_load, byte_done;
  logic [BYTE_W-1:0] rx_byte, rd_data;
  logic [ADDR_W-1:0] addr_q, addr_nxt, load_addr;
  logic              in_cmd_q, is_rd_q, oe_q, wv_q;
  wr_evt_t           wr_q;

  spi_regport_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i({cs_n, sclk, sdi}), .sync_o(sync_v)
  );
  assign {cs_idle, sclk_s, sdi_s} = sync_v;

  spi_regport_edge u_edge (
    .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .active(!cs_idle),
    .cpol(cpol), .cpha(cpha), .sample_o(sample_evt), .shift_o(shift_evt)
  );

  assign addr_nxt  = addr_q + 1'b1;
  assign tx_load   = byte_done && (in_cmd_q ? rx_byte[BYTE_W-1] : is_rd_q);
  assign load_addr = in_cmd_q ? rx_byte[ADDR_W-1:0] : addr_nxt;

  spi_regport_shift #(.W(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .clear(cs_idle), .sample(sample_evt),
    .shift(shift_evt), .sdi_s(sdi_s), .load(tx_load), .load_data(rd_data),
    .byte_done(byte_done), .byte_o(rx_byte), .sdo_bit(sdo_d)
  );

  spi_regport_regs #(.NREG(NREG), .W(BYTE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(wv_q), .waddr(wr_q.addr[IDX_W-1:0]),
    .wdata(wr_q.data), .raddr(load_addr[IDX_W-1:0]), .rdata(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_cmd_q <= 1'b1;
      is_rd_q  <= 1'b0;
      oe_q     <= 1'b0;
      wv_q     <= 1'b0;
      addr_q   <= '0;
      wr_q     <= '0;
    end else if (cs_idle) begin
      in_cmd_q <= 1'b1;
      is_rd_q  <= 1'b0;
      oe_q     <= 1'b0;
      wv_q     <= 1'b0;
    end else begin
      wv_q <= 1'b0;
      if (byte_done) begin
        if (in_cmd_q) begin
          in_cmd_q <= 1'b0;
          is_rd_q  <= rx_byte[BYTE_W-1];
          oe_q     <= rx_byte[BYTE_W-1];
          addr_q   <= rx_byte[ADDR_W-1:0];
        end else if (is_rd_q) begin
          addr_q <= addr_nxt;
        end else begin
          wv_q      <= 1'b1;
          wr_q.addr <= addr_q;
          wr_q.data <= rx_byte;
          addr_q    <= addr_nxt;
        end
      end
    end
  end

  assign sdo_oe   = oe_q;
  assign wr_valid = wv_q;
  assign wr_addr  = wr_q.addr;
  assign wr_data  = wr_q.data;
endmodule

// File: rtl/spi_regport_chk.sv
module spi_regport_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_idle,
  input logic sdo_oe,
  input logic sdo_d,
  input logic wr_valid,
  input logic sample_evt,
  input logic shift_evt,
  input logic tx_load
);
  a_r5_oe_drops_on_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    cs_idle |=> !sdo_oe);

  a_r2_single_cycle_commit: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);

  a_r5_no_commit_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !sdo_oe);

  a_r8_commit_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !$past(cs_idle));

  a_r4_sdo_holds_between_edges: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe && $past(sdo_oe) && !$past(shift_evt) && !$past(tx_load)) |-> $stable(sdo_d));

  a_r6_edges_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_evt && shift_evt));
endmodule

bind spi_regport spi_regport_chk u_chk (.*);

// File: tb/spi_regport_bench.sv
module spi_regport_bench;
  localparam int NREG = 16;
  localparam int H    = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, cpol, cpha, sclk, cs_n, sdi;
  logic sdo_d, sdo_oe, wr_valid;
  logic [6:0] wr_addr;
  logic [7:0] wr_data;

  spi_regport #(.NREG(NREG)) u_spi_regport (
    .clk(clk), .rst_n(rst_n), .cpol(cpol), .cpha(cpha), .sclk(sclk), .cs_n(cs_n),
    .sdi(sdi), .sdo_d(sdo_d), .sdo_oe(sdo_oe), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );

  int errors = 0;
  int checks = 0;
  int idle_cnt = 0;
  bit done = 0;
  logic [7:0]  model [NREG];
  logic [14:0] exp_q [$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Per-clock comparison against the reference model.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (wr_valid) begin
        if (exp_q.size() == 0) begin
          check(0, "R7/R8", "unexpected write event", {wr_addr, wr_data}, 0);
        end else begin
          logic [14:0] e;
          e = exp_q.pop_front();
          check({wr_addr, wr_data} == e, "R1/R2", "write event addr,data",
                {wr_addr, wr_data}, e);
        end
      end
      if (cs_n) idle_cnt++; else idle_cnt = 0;
      if (idle_cnt > 4) check(sdo_oe == 1'b0, "R5", "oe while deselected", sdo_oe, 0);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog", "run did not end", 0, 1);
    done = 1;
    finish_run();
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_bit(input logic b, input bit rd_ph, input logic exp_b, input string req);
    if (!cpha) begin
      sdi = b;
      wait_n(H);
      check(sdo_oe == rd_ph, "R5", "oe at sample edge", sdo_oe, rd_ph);
      if (rd_ph) check(sdo_d == exp_b, req, "read bit", sdo_d, exp_b);
      sclk = ~cpol;
      wait_n(H);
      sclk = cpol;
    end else begin
      sclk = ~cpol;
      sdi  = b;
      wait_n(H);
      check(sdo_oe == rd_ph, "R5", "oe at sample edge", sdo_oe, rd_ph);
      if (rd_ph) check(sdo_d == exp_b, req, "read bit", sdo_d, exp_b);
      sclk = cpol;
      wait_n(H);
    end
  endtask

  task automatic do_byte(input logic [7:0] tx, input bit rd_ph, input logic [7:0] exp,
                         input int nbits, input string req);
    for (int i = 0; i < nbits; i++) do_bit(tx[7-i], rd_ph, exp[7-i], req);
  endtask

  task automatic sel();
    sclk = cpol;
    cs_n = 1'b0;
    wait_n(H);
  endtask

  task automatic desel();
    wait_n(H);
    cs_n = 1'b1;
    wait_n(3 * H);
  endtask

  task automatic set_mode(input int m);
    cpol = m[1];
    cpha = m[0];
    sclk = cpol;
    wait_n(3 * H);
  endtask

  task automatic wr_burst(input logic [6:0] a, input int n, input logic [7:0] seed);
    logic [6:0] ad;
    ad = a;
    sel();
    do_byte({1'b0, a}, 0, 8'h00, 8, "R1");
    for (int k = 0; k < n; k++) begin
      logic [7:0] d;
      d = seed + 8'(k * 8'h3B);
      exp_q.push_back({ad, d});
      model[ad % NREG] = d;
      do_byte(d, 0, 8'h00, 8, "R2");
      ad = ad + 7'd1;
    end
    desel();
    check(exp_q.size() == 0, "R2", "write events outstanding", exp_q.size(), 0);
  endtask

  task automatic rd_burst(input logic [6:0] a, input int n, input string req);
    logic [6:0] ad;
    ad = a;
    sel();
    do_byte({1'b1, a}, 0, 8'h00, 8, "R1");
    for (int k = 0; k < n; k++) begin
      do_byte(8'hA5, 1, model[ad % NREG], 8, req);
      ad = ad + 7'd1;
    end
    desel();
  endtask

  initial begin
    rst_n = 1'b0; cpol = 1'b0; cpha = 1'b0; sclk = 1'b0; cs_n = 1'b1; sdi = 1'b0;
    for (int i = 0; i < NREG; i++) model[i] = 8'h00;
    wait_n(5);
    rst_n = 1'b1;
    wait_n(3 * H);
    check(wr_valid == 1'b0, "R9", "wr_valid after reset", wr_valid, 0);
    check(sdo_oe == 1'b0, "R9", "sdo_oe after reset", sdo_oe, 0);
    rd_burst(7'h0A, 2, "R9");

    // R6 / R3 / R4: bursts in every mode
    for (int m = 0; m < 4; m++) begin
      set_mode(m);
      wr_burst(7'(m * 3), 3, 8'(8'h81 + m * 8'h17));
      rd_burst(7'(m * 3), 3, "R6/R3/R4");
    end

    // R2 / R3: address wrap at the top of the space
    set_mode(1);
    wr_burst(7'h7E, 3, 8'hC3);
    rd_burst(7'h7E, 3, "R3");

    // R10: aliasing through high address bits
    set_mode(2);
    wr_burst(7'h15, 1, 8'h3C);
    rd_burst(7'h05, 1, "R10");
    rd_burst(7'h45, 1, "R10");

    // R7: abort inside a write data byte, in two modes
    for (int m = 0; m < 4; m += 3) begin
      set_mode(m);
      sel();
      do_byte({1'b0, 7'h02}, 0, 8'h00, 8, "R7");
      do_byte(8'h5A, 0, 8'h00, 7, "R7");
      cs_n = 1'b1;
      wait_n(3 * H);
      sclk = cpol;
      rd_burst(7'h02, 1, "R7");
    end

    // R7: abort in the command byte and in read data, then a fresh write
    set_mode(0);
    sel();
    do_byte({1'b0, 7'h04}, 0, 8'h00, 4, "R7");
    cs_n = 1'b1;
    wait_n(3 * H);
    sclk = cpol;
    wr_burst(7'h08, 1, 8'h96);
    sel();
    do_byte({1'b1, 7'h08}, 0, 8'h00, 8, "R7");
    do_byte(8'h00, 1, model[8], 3, "R7");
    cs_n = 1'b1;
    wait_n(3 * H);
    sclk = cpol;
    wr_burst(7'h09, 2, 8'h4E);
    rd_burst(7'h08, 3, "R7");

    // R8: serial activity with chip select high
    set_mode(3);
    for (int i = 0; i < 40; i++) begin
      sclk = ~sclk;
      sdi  = (i % 3 == 0);
      wait_n(H);
    end
    sclk = cpol;
    wait_n(3 * H);
    check(sdo_oe == 1'b0, "R8", "oe after idle toggling", sdo_oe, 0);
    rd_burst(7'h00, 4, "R8");

    check(exp_q.size() == 0, "R2", "write events outstanding at end", exp_q.size(), 0);
    done = 1;
    finish_run();
  end
endmodule